// File: doc/BRIEF.md
# I2C EEPROM Slave with Page Write

This block is the serial front end of a 256-byte nonvolatile-style memory, with the storage modelled as a register array. It watches SCL and SDA, which arrive already synchronized to a fast system clock. It pulls SDA low through an open-drain enable. It answers one bus address, made of a fixed four-bit device pattern and three strap pins. It has an internal word-address counter, and after every accepted write it runs a timed internal write cycle.

A write transfer carries a word address followed by one or more data bytes. The data bytes go into a four-slot staging buffer. The buffer is copied into the array only when a clean STOP arrives. Successive bytes advance only the two low address bits, so a long burst wraps inside its page. A read transfer sends the byte at the counter and then moves the counter on. A random read is a write header with a word address, followed by a repeated START and a read header. A sequential read keeps going for as long as the master acknowledges, and the counter wraps from the top of the array to zero.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset SDA is released (sda_oe_o = 0), the address counter is 0 and every memory byte reads 0x00.
- R2: The slave acknowledges only an address byte whose bits [7:4] equal 4'b1010 and whose bits [3:1] equal strap_i. Bit 0 selects the direction: 0 for write, 1 for read. For any other address byte it drives no ACK, and it leaves SDA released for the rest of that transfer.
- R3: The sequence START, write header, word address A, one data byte D, STOP stores D at A and leaves the counter at A with its two low bits incremented.
- R4: In a write burst, each data byte advances only address bits [1:0] and bits [7:2] stay fixed. A fifth byte therefore lands on the first location that the burst wrote.
- R5: The array changes only at STOP, and only in the page slots that received a byte. Other locations in the same page keep their contents.
- R6: After a STOP that commits at least one byte, the slave refuses to acknowledge its address for WRITE_CYCLES system clocks. After that it acknowledges again.
- R7: A read header makes the slave send the byte at the counter, MSB first, and advance the counter by one. If the master issues STOP after the eighth bit without a ninth clock, the slave releases SDA and the counter does not advance again.
- R8: A random read (write header, word address, repeated START, read header) returns the byte at that address and starts no internal write cycle.
- R9: While the master acknowledges, the slave keeps sending the byte at the next address, using the full 8-bit counter, so the address wraps from 0xFF to 0x00.
- R10: A START or STOP that arrives after at least one bit of a data byte and before its eighth bit discards all staged data. The array is unchanged and no write cycle starts.
- R11: The slave changes its SDA drive only after an SCL falling edge or at a START/STOP, so SDA is stable while SCL is high during a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (resolved bus level) |
| strap_i | input | 3 | Address strap pins, matched against address bits [3:1] |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Two functions can act in the same system-clock cycle: the STOP detector's commit decision and the data shifter's reaction to the SCL rise that every STOP needs. That rise has already counted a phantom bit when the STOP is judged. Both cases are provoked from the bus. In the first, a STOP follows directly after a data ACK and the staged bytes must be committed. In the second, a STOP or repeated START follows a few bits of a byte and everything staged must be dropped. Each outcome is judged at the ports: by reading the array back, and by whether the next address poll is acknowledged at once or refused while a write cycle runs.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } slv_state_e;

  // True when an address byte selects this device, ignoring the direction bit.
  function automatic logic dev_match(input logic [BYTE_W-1:0] hdr,
                                     input logic [3:0] id,
                                     input logic [2:0] pins);
    return (hdr[7:4] == id) && (hdr[3:1] == pins);
  endfunction

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA moving while SCL stays high marks a bus condition.
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (kick)          remain <= CW'(CYCLES);
    else if (remain != '0)  remain <= remain - CW'(1);
  end

  assign busy = (remain != '0);

  assert_kick_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> busy);
  assert_busy_needs_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(kick));

endmodule

// File: rtl/i2c_page_buffer.sv
module i2c_page_buffer #(
  parameter int PAGE_BYTES = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clear,
  input  logic                                 wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0]        wr_idx,
  input  logic [7:0]                           wr_data,
  output logic [PAGE_BYTES-1:0][7:0]           slot_data,
  output logic [PAGE_BYTES-1:0]                slot_valid
);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_data[g]  <= '0;
        slot_valid[g] <= 1'b0;
      end else if (clear) begin
        slot_valid[g] <= 1'b0;
      end else if (wr_en && (wr_idx == g)) begin
        slot_data[g]  <= wr_data;
        slot_valid[g] <= 1'b1;
      end
    end
  end

  assert_stage_marks_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> slot_valid[$past(wr_idx)]);
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (slot_valid == '0));

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_eeprom_pkg::*;
#(
  parameter logic [3:0] DEV_ID       = 4'b1010,
  parameter int         AW           = 8,
  parameter int         PAGE_BYTES   = 4,
  parameter int         WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int DEPTH = 1 << AW;

  // Next address inside a page: only the low PG_W bits advance.
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    return {a[AW-1:PG_W], a[PG_W-1:0] + PG_W'(1)};
  endfunction

  logic scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, pb_wr, pb_clear, hdr_done;
  logic [PAGE_BYTES-1:0][7:0] pb_data;
  logic [PAGE_BYTES-1:0]      pb_valid;

  slv_state_e      st, ack_next;
  logic [3:0]      bitcnt;
  logic [7:0]      rx, tx, byte_in, rd_byte;
  logic            sda_oe_q, ack_on, acked;
  logic [AW-1:0]   cnt;
  logic [7:0]      mem [DEPTH];

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(commit), .busy(busy)
  );

  i2c_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n), .clear(pb_clear), .wr_en(pb_wr),
    .wr_idx(cnt[PG_W-1:0]), .wr_data(byte_in),
    .slot_data(pb_data), .slot_valid(pb_valid)
  );

  assign byte_in  = {rx[6:0], sda_i};
  assign rd_byte  = mem[cnt];
  assign hdr_done = (st == ST_DEV) && scl_rise && (bitcnt == 4'd7);
  assign pb_wr    = (st == ST_WDATA) && scl_rise && (bitcnt == 4'd7);
  assign pb_clear = start_det || stop_det;
  // The STOP's own SCL rise counts one phantom bit, so a count of 0 or 1 is a byte boundary.
  assign commit   = stop_det && (st == ST_WDATA) && (bitcnt <= 4'd1) && (pb_valid != '0);
  assign sda_oe_o = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ack_next <= ST_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      sda_oe_q <= 1'b0;
      cnt      <= '0;
      ack_on   <= 1'b0;
      acked    <= 1'b0;
    end else if (start_det) begin
      st       <= ST_DEV;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
      ack_on   <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      sda_oe_q <= 1'b0;
      ack_on   <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          rx     <= byte_in;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            st     <= ST_ACK;
            if (st == ST_DEV) begin
              if (dev_match(byte_in, DEV_ID, strap_i) && !busy)
                ack_next <= byte_in[0] ? ST_RDATA : ST_WADDR;
              else
                st <= ST_IDLE;
            end else if (st == ST_WADDR) begin
              cnt      <= AW'(byte_in);
              ack_next <= ST_WDATA;
            end else begin
              cnt      <= page_step(cnt);
              ack_next <= ST_WDATA;
            end
          end
        end
        ST_RDATA: bitcnt <= bitcnt + 4'd1;
        ST_RACK:  acked  <= ~sda_i;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        ST_ACK: begin
          if (!ack_on) begin
            sda_oe_q <= 1'b1;
            ack_on   <= 1'b1;
          end else begin
            ack_on   <= 1'b0;
            sda_oe_q <= 1'b0;
            bitcnt   <= '0;
            st       <= ack_next;
            if (ack_next == ST_RDATA) begin
              tx       <= rd_byte;
              sda_oe_q <= ~rd_byte[7];
              cnt      <= cnt + AW'(1);
            end
          end
        end
        ST_RDATA: begin
          if (bitcnt == 4'd8) begin
            sda_oe_q <= 1'b0;
            acked    <= 1'b0;
            st       <= ST_RACK;
          end else begin
            sda_oe_q <= ~tx[3'(4'd7 - bitcnt)];
          end
        end
        ST_RACK: begin
          if (acked) begin
            tx       <= rd_byte;
            sda_oe_q <= ~rd_byte[7];
            cnt      <= cnt + AW'(1);
            bitcnt   <= '0;
            st       <= ST_RDATA;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // Memory array: written only by a committed page.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pb_valid[i]) mem[{cnt[AW-1:PG_W], PG_W'(i)}] <= pb_data[i];
    end
  end

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE && !sda_oe_q));
  assert_busy_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_done && busy) |=> (st == ST_IDLE));
  assert_page_high_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr |=> (cnt[AW-1:PG_W] == $past(cnt[AW-1:PG_W])));
  assert_abort_no_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && st == ST_WDATA && bitcnt > 4'd1) |=> !busy);
  assert_sda_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_q) |-> $past(scl_fall || start_det || stop_det));

endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;

  localparam int          Q      = 4;
  localparam int          WR_CYC = 1000;
  localparam logic [2:0]  STRAP  = 3'b101;
  localparam logic [7:0]  HW     = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0]  HR     = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  bit stab_ok;

  always #10 clk = ~clk;

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    scl_m = 1'b0; tick(Q);
  endtask

  // mode 0: NACK ninth clock, 1: ACK ninth clock, 2: no ninth clock
  task automatic recv_byte(output logic [7:0] b, input int mode);
    logic v1, v2;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_m = 1'b1; tick(1); v1 = sda_bus;
      tick(Q-1); v2 = sda_bus; b[7-i] = v2;
      if (v1 != v2) stab_ok = 1'b0;
      scl_m = 1'b0;
    end
    if (mode != 2) begin
      sda_m = (mode == 1) ? 1'b0 : 1'b1;
      tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
    end
  endtask

  task automatic write_tx(input logic [7:0] a, input int n, output bit ok);
    bit k;
    ok = 1'b1;
    bus_start();
    send_byte(HW, k); ok &= k;
    send_byte(a, k);  ok &= k;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], k); ok &= k; end
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start(); send_byte(HW, ack); bus_stop();
  endtask

  task automatic cur_read(input int mode, output logic [7:0] b, output bit ack);
    bus_start(); send_byte(HR, ack); recv_byte(b, mode); bus_stop();
  endtask

  task automatic seq_read(input logic [7:0] a, input int n, output bit ok);
    bit k;
    ok = 1'b1;
    bus_start();
    send_byte(HW, k); ok &= k;
    send_byte(a, k);  ok &= k;
    bus_start();
    send_byte(HR, k); ok &= k;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], (i == n-1) ? 0 : 1);
    bus_stop();
  endtask

  task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
    bit ok;
    wbuf[0] = d; write_tx(a, 1, ok);
    chk("R3 byte write acked", ok, 1);
    tick(WR_CYC + 100);
  endtask

  task automatic t_reset();
    logic [7:0] b; bit ack;
    chk("R1 SDA released after reset", sda_bus, 1);
    chk("R1 sda_oe low after reset", sda_oe, 0);
    stab_ok = 1'b1;
    cur_read(0, b, ack);
    chk("R1 read header acked", ack, 1);
    chk("R1 counter 0 and memory zero", b, 8'h00);
    chk("R11 data stable while SCL high", stab_ok, 1);
  endtask

  task automatic t_mismatch();
    bit ack, k;
    bus_start();
    send_byte({4'b1010, 3'b001, 1'b0}, ack);
    chk("R2 wrong strap refused", ack, 0);
    send_byte(8'h00, k);
    chk("R2 SDA stays released after refusal", k, 0);
    bus_stop();
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
    chk("R2 wrong device pattern refused", ack, 0);
  endtask

  task automatic t_byte_write();
    bit ack, ok; logic [7:0] b;
    byte_wr(8'h11, 8'h6B);
    wbuf[0] = 8'h5A; write_tx(8'h10, 1, ok);
    chk("R2 matching address acked", ok, 1);
    poll(ack);
    chk("R6 refused during write cycle", ack, 0);
    tick(WR_CYC + 100);
    poll(ack);
    chk("R6 acked after write cycle", ack, 1);
    cur_read(0, b, ack);
    chk("R3 counter at address plus one", b, 8'h6B);
    seq_read(8'h10, 1, ok);
    chk("R8 random read byte", rbuf[0], 8'h5A);
    poll(ack);
    chk("R8 random read starts no write cycle", ack, 1);
  endtask

  task automatic t_page_wrap();
    bit ack, ok; logic [7:0] b;
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_tx(8'h30, 5, ok);
    chk("R4 five-byte burst acked", ok, 1);
    tick(WR_CYC + 100);
    cur_read(0, b, ack);
    chk("R4 counter wrapped inside page", b, 8'hC1);
    seq_read(8'h30, 5, ok);
    chk("R4 fifth byte overwrote first slot", rbuf[0], 8'hC4);
    chk("R4 slot 1", rbuf[1], 8'hC1);
    chk("R4 slot 3", rbuf[3], 8'hC3);
    chk("R9 sequential read crosses page", rbuf[4], 8'h00);
  endtask

  task automatic t_partial_page();
    bit ok;
    byte_wr(8'h41, 8'h11);
    wbuf[0] = 8'h22; wbuf[1] = 8'h33;
    write_tx(8'h42, 2, ok);
    tick(WR_CYC + 100);
    seq_read(8'h40, 4, ok);
    chk("R5 unwritten slot untouched", rbuf[0], 8'h00);
    chk("R5 earlier byte kept", rbuf[1], 8'h11);
    chk("R5 new byte 0x42", rbuf[2], 8'h22);
    chk("R5 new byte 0x43", rbuf[3], 8'h33);
  endtask

  task automatic t_seq_wrap();
    bit ok, ack; logic [7:0] b;
    byte_wr(8'hFF, 8'hEE);
    byte_wr(8'h00, 8'h99);
    byte_wr(8'h01, 8'h42);
    byte_wr(8'h02, 8'h43);
    seq_read(8'hFF, 2, ok);
    chk("R9 byte at 0xFF", rbuf[0], 8'hEE);
    chk("R9 counter wraps to 0x00", rbuf[1], 8'h99);
    cur_read(2, b, ack);
    chk("R7 read without ninth clock", b, 8'h42);
    tick(2);
    chk("R7 SDA released after STOP", sda_bus, 1);
    cur_read(0, b, ack);
    chk("R7 counter advanced once", b, 8'h43);
  endtask

  task automatic t_abort();
    bit ack, k, ok;
    bus_start(); send_byte(HW, k); send_byte(8'h50, k);
    send_byte(8'h66, k); send_bits(8'hFF, 3); bus_stop();
    poll(ack);
    chk("R10 STOP abort starts no write cycle", ack, 1);
    seq_read(8'h50, 1, ok);
    chk("R10 STOP abort left array unchanged", rbuf[0], 8'h00);
    bus_start(); send_byte(HW, k); send_byte(8'h51, k);
    send_byte(8'h77, k); send_bits(8'hF0, 4);
    bus_start(); send_byte(HW, k); bus_stop();
    poll(ack);
    chk("R10 START abort starts no write cycle", ack, 1);
    seq_read(8'h51, 1, ok);
    chk("R10 START abort left array unchanged", rbuf[0], 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_page_wrap();
    t_partial_page();
    stab_ok = 1'b1;
    t_seq_wrap();
    chk("R11 read data stable while SCL high", stab_ok, 1);
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule